// File: doc/BRIEF.md
# Qualified Power-Good Relay

This block forwards two board power-good levels to the host. The standby-rail good level drives an active-low resume-reset line, where high means released. The main-rail good level drives the host power-ok line. Both inputs are asynchronous single bits. Each passes through a synchroniser before any decision is made.

A rising level reaches its output only after a minimum stable time. That time is counted in pulses of a one-cycle millisecond tick supplied by the system. A falling level reaches its output at once. The main-rail level counts as high only while the standby-rail level is also high, because the main good signal can float high when standby power is absent. A single-cycle change strobe marks every cycle in which either output takes a new value.

Top module: `pgood_relay`

## Requirements
- R1: `rsm_rst_n` goes high only after the synchronised `stby_pg_in` has been seen high, and it is low whenever the synchronised `stby_pg_in` is low.
- R2: `host_pwrok` is never raised while the synchronised `stby_pg_in` is low, whatever `main_pg_in` and `ms_tick` do.
- R3: With `STBY_DLY_EN`=1, `rsm_rst_n` rises on the clock edge that samples the `STBY_DLY_MS`-th `ms_tick` (default 10) of a pending rise. Pending starts on the edge after the qualified level is first seen high, so a tick sampled on that first edge is not counted. With `STBY_DLY_EN`=0 it rises on that first edge.
- R4: `host_pwrok` rises on the clock edge that samples the `MAIN_DLY_MS`-th `ms_tick` (default 1) of a pending rise of the qualified main level, using the same pending rule as R3.
- R5: A falling input reaches its output on the third rising clock edge after it is driven: two synchroniser stages plus one register. No tick is needed.
- R6: If the qualified level drops while a rise is pending, the rise is cancelled and the tick count is cleared. A later rise needs the full tick count again.
- R7: `out_chg` is high for exactly the cycles in which either output differs from its value in the previous cycle. When both outputs change on the same edge it is still a single one-cycle pulse.
- R8: While `rst_n` is low, `rsm_rst_n`, `host_pwrok` and `out_chg` are all 0.
- R9: When the qualified level already equals its output, ticks and input activity change nothing and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| stby_pg_in | input | 1 | Standby-rail power good, asynchronous |
| main_pg_in | input | 1 | Main-rail power good, asynchronous |
| rsm_rst_n | output | 1 | Active-low resume reset to the host; high means released |
| host_pwrok | output | 1 | Power-ok to the host |
| out_chg | output | 1 | One-cycle strobe when either output changes |

## Verification
Two functions can land on the same edge.

The first is a standby fall while both outputs are high. It makes both the resume-reset line and power-ok drop together. The bench checks that the fall arrives on the third edge and that `out_chg` is a single one-cycle pulse, not two.

The second is a tick that arrives on the same edge on which the qualified level first becomes pending. The bench provokes this by driving a tick on exactly that edge. It then judges that the tick was not counted, because the outputs still need the full number of later ticks.

// File: rtl/pg_relay_pkg.sv
package pg_relay_pkg;

    typedef enum logic [1:0] {
        PH_LOW  = 2'd0,
        PH_WAIT = 2'd1,
        PH_HIGH = 2'd2
    } pg_phase_e;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/pg_rise_gate.sv
module pg_rise_gate
    import pg_relay_pkg::*;
#(
    parameter int unsigned DLY_MS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic tick_i,
    output logic lvl_o,
    output logic flip_o
);
    localparam int unsigned CW = cnt_width(DLY_MS);

    typedef struct packed {
        pg_phase_e       phase;
        logic [CW-1:0]   cnt;
    } gate_st_t;

    gate_st_t st_d, st_q;

    generate
        if (DLY_MS == 0) begin : g_immediate
            always_comb begin
                st_d       = st_q;
                st_d.cnt   = '0;
                st_d.phase = lvl_i ? PH_HIGH : PH_LOW;
            end
        end else begin : g_delayed
            localparam logic [CW-1:0] LAST = CW'(DLY_MS - 1);
            always_comb begin
                st_d = st_q;
                unique case (st_q.phase)
                    PH_LOW: begin
                        st_d.cnt = '0;
                        if (lvl_i) st_d.phase = PH_WAIT;
                    end
                    PH_WAIT: begin
                        if (!lvl_i) begin
                            st_d.phase = PH_LOW;
                            st_d.cnt   = '0;
                        end else if (tick_i) begin
                            if (st_q.cnt == LAST) begin
                                st_d.phase = PH_HIGH;
                                st_d.cnt   = '0;
                            end else begin
                                st_d.cnt = st_q.cnt + 1'b1;
                            end
                        end
                    end
                    PH_HIGH: begin
                        st_d.cnt = '0;
                        if (!lvl_i) st_d.phase = PH_LOW;
                    end
                    default: begin
                        st_d.phase = PH_LOW;
                        st_d.cnt   = '0;
                    end
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_LOW;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o  = (st_q.phase == PH_HIGH);
    assign flip_o = (st_d.phase == PH_HIGH) != (st_q.phase == PH_HIGH);
endmodule

// File: rtl/pgood_relay.sv
module pgood_relay
    import pg_relay_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MAIN_DLY_MS = 1,
    parameter int unsigned STBY_DLY_MS = 10,
    parameter bit          STBY_DLY_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic stby_pg_in,
    input  logic main_pg_in,
    output logic rsm_rst_n,
    output logic host_pwrok,
    output logic out_chg
);
    localparam int unsigned STBY_EFF = STBY_DLY_EN ? STBY_DLY_MS : 0;

    typedef struct packed {
        logic chg;
    } top_st_t;

    logic [1:0] pg_sync_w;
    logic       stby_qual, main_qual;
    logic       stby_lvl, main_lvl;
    logic       stby_flip, main_flip;
    top_st_t    top_d, top_q;

    pg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({main_pg_in, stby_pg_in}),
        .sync_o  (pg_sync_w)
    );

    // Main rail counts only while standby rail is good.
    assign stby_qual = pg_sync_w[0];
    assign main_qual = pg_sync_w[1] & pg_sync_w[0];

    pg_rise_gate #(.DLY_MS(STBY_EFF)) u_stby_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (stby_qual),
        .tick_i (ms_tick),
        .lvl_o  (stby_lvl),
        .flip_o (stby_flip)
    );

    pg_rise_gate #(.DLY_MS(MAIN_DLY_MS)) u_main_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (main_qual),
        .tick_i (ms_tick),
        .lvl_o  (main_lvl),
        .flip_o (main_flip)
    );

    always_comb begin
        top_d     = top_q;
        top_d.chg = stby_flip | main_flip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign rsm_rst_n  = stby_lvl;
    assign host_pwrok = main_lvl;
    assign out_chg    = top_q.chg;
endmodule

// File: rtl/pgood_relay_chk.sv
module pgood_relay_chk #(
    parameter int unsigned STBY_EFF    = 10,
    parameter int unsigned MAIN_DLY_MS = 1
) (
    input logic clk,
    input logic rst_n,
    input logic ms_tick,
    input logic stby_pg_in,
    input logic rsm_rst_n,
    input logic host_pwrok,
    input logic out_chg
);
    a_r1_rsm_needs_stby: assert property (@(posedge clk) disable iff (!rst_n)
        rsm_rst_n |-> $past(stby_pg_in, 3));

    a_r2_pwrok_needs_stby: assert property (@(posedge clk) disable iff (!rst_n)
        host_pwrok |-> $past(stby_pg_in, 3));

    a_r7_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsm_rst_n != $past(rsm_rst_n)) || (host_pwrok != $past(host_pwrok))) |-> out_chg);

    a_r7_strobe_only_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        out_chg |-> ((rsm_rst_n != $past(rsm_rst_n)) || (host_pwrok != $past(host_pwrok))));

    generate
        if (STBY_EFF != 0) begin : g_stby_tick
            a_r3_rsm_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rsm_rst_n) |-> $past(ms_tick));
        end
        if (MAIN_DLY_MS != 0) begin : g_main_tick
            a_r4_pwrok_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(host_pwrok) |-> $past(ms_tick));
        end
    endgenerate
endmodule

bind pgood_relay pgood_relay_chk #(
    .STBY_EFF    (STBY_EFF),
    .MAIN_DLY_MS (MAIN_DLY_MS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .stby_pg_in (stby_pg_in),
    .rsm_rst_n  (rsm_rst_n),
    .host_pwrok (host_pwrok),
    .out_chg    (out_chg)
);

// File: tb/pgood_relay_tb_top.sv
module pgood_relay_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic stby = 1'b0;
    logic main = 1'b0;
    logic rsm, pwr, chg;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pgood_relay dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ms_tick    (tick),
        .stby_pg_in (stby),
        .main_pg_in (main),
        .rsm_rst_n  (rsm),
        .host_pwrok (pwr),
        .out_chg    (chg)
    );

    // Row: {stby, main, tick, exp_rsm, exp_pwrok, exp_chg}
    localparam logic [5:0] VEC [20] = '{
        6'b110_000, 6'b110_000, 6'b111_000,             // pending starts; first tick ignored (R3)
        6'b111_011,                                     // main rises after 1 tick (R4)
        6'b111_010, 6'b111_010, 6'b111_010, 6'b111_010,
        6'b111_010, 6'b111_010, 6'b111_010, 6'b111_010,
        6'b111_111,                                     // 10th tick: resume reset released (R3)
        6'b111_110,                                     // already high: nothing (R9)
        6'b010_110, 6'b010_110,
        6'b010_001,                                     // both fall together, one strobe (R5, R7)
        6'b011_000, 6'b011_000, 6'b011_000              // main without standby (R2)
    };

    task automatic step(input logic s, input logic m, input logic t);
        @(negedge clk);
        stby = s; main = m; tick = t;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {rsm,pwrok,chg} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; stby = 1'b0; main = 1'b0; tick = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk({rsm, pwr, chg}, 3'b000, "R8 reset state");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        do_reset();

        for (int i = 0; i < 20; i++) begin
            step(VEC[i][5], VEC[i][4], VEC[i][3]);
            chk({rsm, pwr, chg}, VEC[i][2:0],
                $sformatf("R1/R2/R3/R4/R5/R7/R9 table row %0d", i));
        end

        // R6: cancel a pending standby rise, then require the full count again
        do_reset();
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b0, 1'b1);
            chk({rsm, pwr, chg}, 3'b000, "R6 partial count");
        end
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0, 1'b0);
            chk({rsm, pwr, chg}, 3'b000, "R6 drop while pending");
        end
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 9; i++) begin
            step(1'b1, 1'b0, 1'b1);
            chk({rsm, pwr, chg}, 3'b000, "R6 count restarted");
        end
        step(1'b1, 1'b0, 1'b1);
        chk({rsm, pwr, chg}, 3'b101, "R6 R3 full count after cancel");

        // R4/R5: main alone rises after one tick and falls on the third edge
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0);
        chk({rsm, pwr, chg}, 3'b100, "R4 no rise without tick");
        step(1'b1, 1'b1, 1'b1);
        chk({rsm, pwr, chg}, 3'b111, "R4 pwrok rise");
        step(1'b1, 1'b1, 1'b0);
        chk({rsm, pwr, chg}, 3'b110, "R7 strobe lasts one cycle");
        for (int i = 0; i < 2; i++) begin
            step(1'b1, 1'b0, 1'b0);
            chk({rsm, pwr, chg}, 3'b110, "R5 fall not before third edge");
        end
        step(1'b1, 1'b0, 1'b0);
        chk({rsm, pwr, chg}, 3'b101, "R5 pwrok fall on third edge");

        // R9: ticks with input low and output low change nothing
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0, 1'b1);
            chk({rsm, pwr, chg}, 3'b100, "R9 ticks with main low");
        end

        // R8: reset while an output is high
        do_reset();

        done = 1'b1;
        finish_run();
    end
endmodule